// File: doc/BRIEF.md
# Sampled PID Compensator with Pulse-Width Output

This block closes a digital control loop for a switching stage. Each time the sample strobe is high, it takes an 8-bit setpoint and an 8-bit measured value, both unsigned, and forms their signed difference. It then evaluates a second-order recursive control law. Two error samples and two duty samples are kept from earlier strobes, and the law weights all of them with four signed coefficients that can be changed at run time.

The new duty command is rounded, clamped to the range of the PWM counter and stored as loop history. A free-running counter with a comparator then turns it into a pulse train on one output pin. A new duty value takes effect only when the counter starts a new period.

If the pole coefficient is set to zero, the law reduces to the incremental (velocity) PID form. In that case the three error weights carry Kp + Ki·Ts + Kd/Ts, −(Kp + 2·Kd/Ts) and Kd/Ts.

Top module: `pid_pwm_core`

## Requirements
- R1: A synchronous reset, while `rst` is high, clears all error and duty history to zero and zeroes the PWM counter and the applied duty. It also holds `duty_out` at 0, `done` low and `pwm_out` low.
- R2: On a strobe the error is the signed 9-bit value `ref_in − meas_in`, with both inputs unsigned. A negative error drives the duty downward.
- R3: On a strobe the raw result is sum = (4096 + s1)·d1 − s1·d2 + a·e + b·e1 + c·e2. The coefficients are signed 16-bit values with 12 fraction bits. The sum is formed at full precision and then rounded as floor((sum + 2048) / 4096), so an exact half rounds upward.
- R4: Without a strobe, no history register changes. `duty_out` holds its value and `done` stays low.
- R5: The rounded result is clamped to 0..2^PWM_W − 1, and the clamped value is what becomes d1. A following strobe therefore starts from the clamped value and never from the raw sum.
- R6: `done` is high for exactly the one cycle after each strobe cycle, and the new duty appears on `duty_out` in that same cycle. Strobes on back-to-back cycles give back-to-back results.
- R7: The PWM counter counts up by one every cycle and wraps after 2^PWM_W cycles. `pwm_out` is high while the counter is below the applied duty, so each period has exactly duty high cycles: 0 means always low and 255 means 255 of 256.
- R8: The applied duty copies `duty_out` only on the cycle in which the counter moves from its maximum value to zero. A period that is already running finishes with its old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One evaluation of the control law per high cycle |
| ref_in | input | IN_W | Setpoint sample, unsigned |
| meas_in | input | IN_W | Measured sample, unsigned |
| coef_a | input | CW | Weight of the current error, signed Q4.12 |
| coef_b | input | CW | Weight of the previous error, signed Q4.12 |
| coef_c | input | CW | Weight of the error two samples back, signed Q4.12 |
| coef_s1 | input | CW | Pole coefficient s1, signed Q4.12 |
| duty_out | output | PWM_W | Latest clamped duty command (d1) |
| done | output | 1 | One-cycle pulse when `duty_out` holds a new value |
| pwm_out | output | 1 | Pulse-width modulated output |

## Verification
A wrong history register stays inside the block until the next strobe or two. It then shows up as a wrong `duty_out` in the cycle of `done`. The scoreboard compares every such result against a software model that keeps its own clamped history, so an error in the shift order, the rounding or the clamping is reported at the first strobe it touches. A fault in the modulator shows at `pwm_out` within one period of 2^PWM_W cycles. The bench measures high-cycle counts over whole periods, and also the length of a period that is running when a new duty arrives, which would expose a duty applied early.

// File: rtl/pid_pwm_core.sv
module pid_pwm_core #(
  parameter int IN_W  = 8,
  parameter int PWM_W = 8,
  parameter int CW    = 16,
  parameter int FRAC  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_stb,
  input  logic [IN_W-1:0]      ref_in,
  input  logic [IN_W-1:0]      meas_in,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  input  logic signed [CW-1:0] coef_s1,
  output logic [PWM_W-1:0]     duty_out,
  output logic                 done,
  output logic                 pwm_out
);
  localparam int EW    = IN_W + 1;
  localparam int ACC_W = CW + PWM_W + IN_W + 4;
  localparam logic [PWM_W-1:0]        DMAX = '1;
  localparam logic signed [CW:0]      ONE  = (CW+1)'(1) <<< FRAC;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] TOP  = ACC_W'({1'b0, DMAX});

  logic signed [EW-1:0]    err, err1, err2;
  logic [PWM_W-1:0]        d1, d2, dsat;
  logic [PWM_W-1:0]        cnt, duty_act;
  logic signed [CW:0]      k1;
  logic signed [ACC_W-1:0] acc, rnd;

  assign err = $signed({1'b0, ref_in}) - $signed({1'b0, meas_in});
  assign k1  = (CW+1)'(coef_s1) + ONE;

  assign acc = ACC_W'(k1)      * ACC_W'($signed({1'b0, d1}))
             - ACC_W'(coef_s1) * ACC_W'($signed({1'b0, d2}))
             + ACC_W'(coef_a)  * ACC_W'(err)
             + ACC_W'(coef_b)  * ACC_W'(err1)
             + ACC_W'(coef_c)  * ACC_W'(err2);

  assign rnd = (acc + HALF) >>> FRAC;

  always_comb begin
    if (rnd < 0)        dsat = '0;
    else if (rnd > TOP) dsat = DMAX;
    else                dsat = rnd[PWM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err1     <= '0;
      err2     <= '0;
      d1       <= '0;
      d2       <= '0;
      done     <= 1'b0;
      cnt      <= '0;
      duty_act <= '0;
    end else begin
      done <= sample_stb;
      if (sample_stb) begin
        err1 <= err;
        err2 <= err1;
        d1   <= dsat;
        d2   <= d1;
      end
      cnt <= cnt + 1'b1;
      if (cnt == DMAX) duty_act <= d1;
    end
  end

  assign duty_out = d1;
  assign pwm_out  = cnt < duty_act;
endmodule

// File: rtl/pid_pwm_core_props.sv
module pid_pwm_core_props #(
  parameter int PWM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_stb,
  input logic             done,
  input logic [PWM_W-1:0] duty_out,
  input logic             pwm_out,
  input logic [PWM_W-1:0] cnt,
  input logic [PWM_W-1:0] duty_act
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (duty_out == '0 && !done && !pwm_out));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ($stable(duty_out) && !done));

  p_done_follows_r6: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> done);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '1) |=> (cnt == PWM_W'($past(cnt) + 1'b1)));

  p_zero_duty_low_r7: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |-> !pwm_out);

  p_apply_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (duty_act == $past(duty_act)));
endmodule

bind pid_pwm_core pid_pwm_core_props #(.PWM_W(PWM_W)) u_props (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .done(done),
  .duty_out(duty_out), .pwm_out(pwm_out), .cnt(cnt), .duty_act(duty_act)
);

// File: tb/pid_pwm_core_bench.sv
module pid_pwm_core_bench;
  localparam int FRAC = 12;
  localparam int ONE  = 1 << FRAC;
  localparam int MAXD = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_stb = 1'b0;
  logic [7:0] ref_in = '0, meas_in = '0;
  logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0, coef_s1 = '0;
  logic [7:0] duty_out;
  logic done, pwm_out;

  int total = 0, fails = 0;
  int exp_q[$];
  int ka, kb, kc, ks;
  longint md1, md2, me1, me2;

  always #2ns clk = ~clk;

  pid_pwm_core u_pid_pwm_core (
    .clk(clk), .rst(rst), .sample_stb(sample_stb),
    .ref_in(ref_in), .meas_in(meas_in),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c), .coef_s1(coef_s1),
    .duty_out(duty_out), .done(done), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected done", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(duty_out == e, "R3 duty result", duty_out, e);
      end
    end
  end

  task automatic set_coef(input int a, input int b, input int c, input int s);
    ka = a; kb = b; kc = c; ks = s;
    coef_a = 16'(a); coef_b = 16'(b); coef_c = 16'(c); coef_s1 = 16'(s);
  endtask

  task automatic do_sample(input int r, input int y);
    longint e, acc, q;
    e   = r - y;
    acc = (ONE + ks) * md1 - ks * md2 + ka * e + kb * me1 + kc * me2;
    q   = (acc + ONE / 2) >>> FRAC;
    if (q < 0) q = 0;
    if (q > MAXD) q = MAXD;
    md2 = md1; md1 = q; me2 = me1; me1 = e;
    exp_q.push_back(int'(q));
    ref_in = 8'(r); meas_in = 8'(y); sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(duty_out == 0, "R1 duty_out in reset", duty_out, 0);
    chk(pwm_out == 1'b0, "R1 pwm_out in reset", pwm_out, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    md1 = 0; md2 = 0; me1 = 0; me2 = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
  endtask

  task automatic find_rise();
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
  endtask

  task automatic run_len(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (pwm_out) n++;
      else break;
    end
  endtask

  initial begin
    #(4ns * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, prev, nd;
    @(negedge clk);
    do_reset();

    // R2: error sign and integrator behaviour with s1 = 0
    set_coef(ONE, 0, 0, 0);
    do_sample(150, 50);
    do_sample(20, 40);
    // R3: exact half rounds upward (80 + 1.5 -> 82)
    set_coef(ONE / 2, 0, 0, 0);
    do_sample(3, 0);
    do_sample(5, 0);
    // R5: clamp high, then continue from the clamped value
    set_coef(2 * ONE, 0, 0, 0);
    do_sample(255, 0);
    set_coef(ONE, 0, 0, 0);
    do_sample(0, 10);
    // R5: clamp low, then recover from zero
    do_sample(0, 255);
    do_sample(5, 0);
    repeat (3) @(negedge clk);

    // R4: no strobe, nothing moves
    prev = duty_out; nd = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) nd++;
    end
    chk(duty_out == prev, "R4 duty held", duty_out, prev);
    chk(nd == 0, "R4 no done without strobe", nd, 0);

    // R3: full recursion, positive pole term
    set_coef(16'sh1800, -16'sh1400, 16'sh0400, 16'sh0800);
    do_sample(120, 100);
    do_sample(130, 100);
    do_sample(90, 100);
    do_sample(100, 100);
    do_sample(200, 50);
    // R3: negative pole term, R6: back-to-back strobes
    set_coef(16'sh0A00, 16'sh0300, -16'sh0200, -16'sh0C00);
    do_sample(180, 20);
    do_sample(60, 90);
    do_sample(140, 100);
    do_sample(100, 140);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every strobe gave done", exp_q.size(), 0);

    // R7/R8: modulator, duty set through d = d1 + e - e1 from clean history
    do_reset();
    set_coef(ONE, -ONE, 0, 0);
    do_sample(200, 0);
    repeat (600) @(negedge clk);
    count_high(n);
    chk(n == 200, "R7 high cycles per period", n, 200);

    // R8: change duty 20 cycles into a period; that period stays at 200
    find_rise();
    n = 1;
    repeat (19) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
    do_sample(50, 0);
    if (pwm_out) n++;
    forever begin
      @(negedge clk);
      if (pwm_out) n++;
      else break;
    end
    chk(n == 200, "R8 running period not cut", n, 200);
    find_rise();
    run_len(n);
    chk(n == 50, "R8 next period uses new duty", n, 50);

    do_sample(0, 0);
    repeat (600) @(negedge clk);
    count_high(n);
    chk(n == 0, "R7 zero duty stays low", n, 0);

    do_sample(255, 0);
    repeat (600) @(negedge clk);
    count_high(n);
    chk(n == 255, "R7 full duty", n, 255);

    // R1: reset forces the output low from a high duty
    do_reset();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule